// File: doc/BRIEF.md
# Per-Channel Latching Clear Controller

This block sits between the data path of a multi-channel converter and the converters themselves. It watches an asynchronous clear pin and, when that pin rises, forces each channel whose clear is enabled to a code programmed for that channel. Channels whose clear is not enabled keep passing their normal output code.

The clear is latching. Once a channel has been forced, it stays at its clear code after the pin falls again, and ignores changes on its normal code input. It returns to the normal code only when a new-data strobe arrives for that channel. A per-channel flag shows which channels are being held at their clear code.

The pin is brought into the clock domain through a synchronizer, and a rising edge is detected there. Clear codes and enables are written through a simple per-channel write port: a channel index, a code and an enable bit, all taken in the same cycle.

Top module: `clr_hold_ctrl`

## Requirements
- R1: After reset every held flag is 0, every output equals its normal code input, every clear code is 0 and every clear enable is off, so a clear edge before any write holds no channel.
- R2: A rise of `clr_async_i` is synchronized through two flops. If the pin is driven high before clock edge k after being low at edge k-1, the held flags change at edge k+2. A pin that stays high triggers only once. A pin that is high at a single edge still triggers.
- R3: A clear edge sets the held flag only of channels whose clear enable is 1. Every other channel keeps its held flag and its output.
- R4: While a channel's held flag is 1, its output slice equals that channel's clear code register, whatever the clear pin level and whatever its normal code input does.
- R5: An `upd_i[k]` strobe sampled at a clock edge clears `held_o[k]`, and from that edge the output slice k follows `live_code_i` slice k.
- R6: When `upd_i[k]` and a clear edge act at the same clock edge on an enabled channel k, the clear wins and the channel is held.
- R7: With `cfg_we_i` high at an edge, channel `cfg_sel_i` (channel k occupies bits [k*12 +: 12] of both code buses) takes `cfg_code_i` as its clear code and `cfg_en_i` as its clear enable from that edge on. A clear edge at that same edge uses the enable held before the write.
- R8: Rewriting the clear code of a held channel changes that channel's output to the new code from the write edge on, and the channel stays held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr_async_i | input | 1 | Asynchronous clear pin, rising edge triggers |
| cfg_we_i | input | 1 | Clear configuration write strobe |
| cfg_sel_i | input | 2 | Channel index for the configuration write |
| cfg_code_i | input | 12 | Clear code to store |
| cfg_en_i | input | 1 | Clear enable to store |
| upd_i | input | 4 | Per-channel new-data strobe |
| live_code_i | input | 48 | Normal per-channel codes, channel k at [k*12 +: 12] |
| dac_code_o | output | 48 | Codes to the converters, channel k at [k*12 +: 12] |
| held_o | output | 4 | Per-channel flag, 1 while the channel is held at its clear code |

## Verification
Directed pulses separate the cases the edge detector must tell apart: a long-high pin that must trigger once, a one-cycle pin that must still trigger, and a clear before any configuration that must do nothing. Mixed enable patterns show that only masked-in channels latch. Live-code changes and pin release while held show the latch holds. A strobe in the same cycle as the clear edge shows the priority. A long random run then mixes pin toggles, configuration writes, strobes and live codes, and compares against a reference model of held flags and codes.

// File: rtl/clr_hold_pkg.sv
package clr_hold_pkg;
   function automatic int sel_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/clr_hold_sync.sv
module clr_hold_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic edge_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("clr_hold_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         last_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], async_i};
         last_q  <= chain_q[STAGES-1];
      end
   end

   assign edge_o = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/clr_hold_chan.sv
module clr_hold_chan #(
   parameter int CODE_W  = 12,
   parameter bit OUT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_edge_i,
   input  logic              cfg_we_i,
   input  logic [CODE_W-1:0] cfg_code_i,
   input  logic              cfg_en_i,
   input  logic              upd_i,
   input  logic [CODE_W-1:0] live_i,
   output logic              en_o,
   output logic              held_o,
   output logic [CODE_W-1:0] code_o
);
   if (CODE_W < 1) begin : g_bad_width
      $error("clr_hold_chan: CODE_W must be positive");
   end

   logic [CODE_W-1:0] clr_code_q;
   logic              en_q;
   logic              held_q;
   logic [CODE_W-1:0] mux_code;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clr_code_q <= '0;
         en_q       <= 1'b0;
      end else if (cfg_we_i) begin
         clr_code_q <= cfg_code_i;
         en_q       <= cfg_en_i;
      end
   end

   // clear has priority over a coinciding data update
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  held_q <= 1'b0;
      else if (clr_edge_i && en_q) held_q <= 1'b1;
      else if (upd_i)              held_q <= 1'b0;
   end

   assign mux_code = held_q ? clr_code_q : live_i;

   if (OUT_REG) begin : g_out_reg
      logic [CODE_W-1:0] out_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) out_q <= '0;
         else        out_q <= mux_code;
      end
      assign code_o = out_q;
   end else begin : g_out_comb
      assign code_o = mux_code;
   end

   assign en_o   = en_q;
   assign held_o = held_q;
endmodule

// File: rtl/clr_hold_ctrl.sv
module clr_hold_ctrl #(
   parameter int NUM_CH      = 4,
   parameter int CODE_W      = 12,
   parameter int SYNC_STAGES = 2,
   parameter bit OUT_REG     = 1'b0,
   localparam int SEL_W      = clr_hold_pkg::sel_width(NUM_CH),
   localparam int BUS_W      = NUM_CH * CODE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_async_i,
   input  logic              cfg_we_i,
   input  logic [SEL_W-1:0]  cfg_sel_i,
   input  logic [CODE_W-1:0] cfg_code_i,
   input  logic              cfg_en_i,
   input  logic [NUM_CH-1:0] upd_i,
   input  logic [BUS_W-1:0]  live_code_i,
   output logic [BUS_W-1:0]  dac_code_o,
   output logic [NUM_CH-1:0] held_o
);
   if (NUM_CH < 1) begin : g_bad_count
      $error("clr_hold_ctrl: NUM_CH must be positive");
   end

   logic              clr_edge;
   logic [NUM_CH-1:0] en_q;

   clr_hold_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (clr_async_i),
      .edge_o  (clr_edge)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic sel_hit;
      assign sel_hit = cfg_we_i && (cfg_sel_i == SEL_W'(c));

      clr_hold_chan #(.CODE_W(CODE_W), .OUT_REG(OUT_REG)) u_chan (
         .clk        (clk),
         .rst_n      (rst_n),
         .clr_edge_i (clr_edge),
         .cfg_we_i   (sel_hit),
         .cfg_code_i (cfg_code_i),
         .cfg_en_i   (cfg_en_i),
         .upd_i      (upd_i[c]),
         .live_i     (live_code_i[c*CODE_W +: CODE_W]),
         .en_o       (en_q[c]),
         .held_o     (held_o[c]),
         .code_o     (dac_code_o[c*CODE_W +: CODE_W])
      );
   end
endmodule

// File: rtl/clr_hold_chk.sv
module clr_hold_chk #(
   parameter int NUM_CH = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              clr_edge,
   input logic [NUM_CH-1:0] en_q,
   input logic [NUM_CH-1:0] held_q,
   input logic [NUM_CH-1:0] upd
);
   assert_edge_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      clr_edge |=> !clr_edge);

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
      assert_enabled_latches_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_edge && en_q[c]) |=> held_q[c]);

      assert_masked_untouched_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (!held_q[c] && !(clr_edge && en_q[c])) |=> !held_q[c]);

      assert_hold_persists_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (held_q[c] && !upd[c]) |=> held_q[c]);

      assert_update_releases_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (upd[c] && !(clr_edge && en_q[c])) |=> !held_q[c]);
   end
endmodule

bind clr_hold_ctrl clr_hold_chk #(.NUM_CH(NUM_CH)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .clr_edge (clr_edge),
   .en_q     (en_q),
   .held_q   (held_o),
   .upd      (upd_i)
);

// File: tb/clr_hold_ctrl_bench.sv
module clr_hold_ctrl_bench;
   localparam int NCH = 4;
   localparam int CW  = 12;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            pin = 1'b0;
   logic            we = 1'b0;
   logic [1:0]      sel = '0;
   logic [CW-1:0]   wcode = '0;
   logic            wen = 1'b0;
   logic [NCH-1:0]  upd = '0;
   logic [NCH*CW-1:0] live = '0;
   logic [NCH*CW-1:0] dac;
   logic [NCH-1:0]  held;

   int total = 0;
   int bad = 0;

   logic [CW-1:0] m_code [NCH];
   logic          m_en   [NCH];
   logic          m_held [NCH];
   logic          p1 = 1'b0, p2 = 1'b0, p3 = 1'b0;

   always #2 clk = ~clk;

   clr_hold_ctrl u_clr_hold_ctrl (
      .clk(clk), .rst_n(rst_n), .clr_async_i(pin), .cfg_we_i(we),
      .cfg_sel_i(sel), .cfg_code_i(wcode), .cfg_en_i(wen), .upd_i(upd),
      .live_code_i(live), .dac_code_o(dac), .held_o(held));

   task automatic chk(input string req, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [CW-1:0] exp_out(input int ch);
      return m_held[ch] ? m_code[ch] : live[ch*CW +: CW];
   endfunction

   task automatic check_all(input string req);
      for (int c = 0; c < NCH; c++) begin
         chk(req, $sformatf("held[%0d]", c), int'(held[c]), int'(m_held[c]));
         chk(req, $sformatf("code[%0d]", c), int'(dac[c*CW +: CW]), int'(exp_out(c)));
      end
   endtask

   // drive one cycle at negedge, update model for the coming edge, check after it
   task automatic step(input string req, input logic p, input logic w, input int s,
                       input int code, input logic e, input logic [NCH-1:0] u,
                       input logic [NCH*CW-1:0] lv);
      logic pulse;
      pin = p; we = w; sel = 2'(s); wcode = CW'(code); wen = e; upd = u; live = lv;
      pulse = p2 & ~p3;
      for (int c = 0; c < NCH; c++) begin
         if (pulse && m_en[c]) m_held[c] = 1'b1;
         else if (u[c])        m_held[c] = 1'b0;
      end
      if (w) begin
         m_code[s] = CW'(code);
         m_en[s]   = e;
      end
      @(posedge clk);
      p3 = p2; p2 = p1; p1 = p;
      @(negedge clk);
      we = 1'b0; upd = '0;
      check_all(req);
   endtask

   task automatic idle(input string req, input logic p, input int n);
      for (int i = 0; i < n; i++) step(req, p, 1'b0, 0, 0, 1'b0, '0, live);
   endtask

   initial begin
      for (int i = 0; i < 50000; i++) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [NCH*CW-1:0] lv;
      logic rp;
      void'($urandom(32'd4711));
      for (int c = 0; c < NCH; c++) begin
         m_code[c] = '0; m_en[c] = 1'b0; m_held[c] = 1'b0;
      end
      live = {12'h444, 12'h333, 12'h222, 12'h111};
      repeat (3) @(negedge clk);
      check_all("R1");
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1");

      // R1: clear before any configuration holds nothing
      idle("R1", 1'b1, 4);
      idle("R1", 1'b0, 3);

      // R7: configure channels 0 and 2 enabled, 1 disabled
      step("R7", 1'b0, 1'b1, 0, 'hABC, 1'b1, '0, live);
      step("R7", 1'b0, 1'b1, 2, 'h123, 1'b1, '0, live);
      step("R7", 1'b0, 1'b1, 1, 'h555, 1'b0, '0, live);

      // R2/R3: rise, held appears at the third edge, only enabled channels
      step("R2", 1'b1, 1'b0, 0, 0, 1'b0, '0, live);
      step("R2", 1'b1, 1'b0, 0, 0, 1'b0, '0, live);
      chk("R2", "held early", int'(held), 0);
      step("R3", 1'b1, 1'b0, 0, 0, 1'b0, '0, live);
      chk("R3", "held mask", int'(held), 'b0101);

      // R4: pin stays high, live changes, then pin falls
      step("R4", 1'b1, 1'b0, 0, 0, 1'b0, '0, {12'hF0F, 12'hE0E, 12'hD0D, 12'hC0C});
      idle("R2", 1'b1, 4);
      idle("R4", 1'b0, 4);
      chk("R4", "code0 held", int'(dac[0 +: CW]), 'hABC);

      // R8: rewrite clear code of held channel 0
      step("R8", 1'b0, 1'b1, 0, 'h777, 1'b1, '0, live);
      chk("R8", "code0 new", int'(dac[0 +: CW]), 'h777);

      // R5: data update releases channel 0
      step("R5", 1'b0, 1'b0, 0, 0, 1'b0, 4'b0001, live);
      chk("R5", "code0 live", int'(dac[0 +: CW]), 'hC0C);

      // R6: update coincides with the clear edge
      step("R6", 1'b1, 1'b0, 0, 0, 1'b0, '0, live);
      step("R6", 1'b0, 1'b0, 0, 0, 1'b0, '0, live);
      step("R6", 1'b0, 1'b0, 0, 0, 1'b0, 4'b1111, live);
      chk("R6", "held after tie", int'(held), 'b0101);

      // R2: single-cycle pin after release triggers again
      step("R5", 1'b0, 1'b0, 0, 0, 1'b0, 4'b1111, live);
      chk("R5", "all released", int'(held), 0);
      step("R2", 1'b1, 1'b0, 0, 0, 1'b0, '0, live);
      idle("R2", 1'b0, 3);
      chk("R2", "short pulse", int'(held), 'b0101);

      // random mix
      rp = 1'b0;
      for (int i = 0; i < 600; i++) begin
         if ($urandom_range(0, 9) == 0) rp = ~rp;
         lv = live;
         if ($urandom_range(0, 3) == 0)
            lv = {12'($urandom), 12'($urandom), 12'($urandom), 12'($urandom)};
         step("R3", rp, ($urandom_range(0, 5) == 0), int'($urandom_range(0, 3)),
              int'($urandom_range(0, 4095)), 1'($urandom), 4'($urandom) & 4'($urandom) & 4'($urandom),
              lv);
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule